// File: doc/BRIEF.md
# Four-Mode 16-Bit Down-Counting Timer

This block is a 16-bit down counter that can be used in four ways, chosen by a two-bit mode field. In pulse-width mode it produces a square wave on its output pin. Each level of that wave lasts as long as a reload register says. In event mode the count steps down once per chosen edge on an external pin instead of once per instruction tick. In capture mode the running count is copied into register A whenever the chosen edge arrives, and the previous copy moves into register B. In difference mode the block itself works out how many ticks passed since the last chosen edge, writes that figure into register A, and restarts the count.

The external pin passes through a two-flop synchronizer before edge detection. A single pending flag records underflows and captures. Software clears it by writing a one to it. An interrupt request is raised while the flag and its enable are both set. Software reaches four registers over a plain write/read strobe bus.

Top module: `mode_timer16`

## Requirements
- R1: Bus addresses are 0 = counter, 1 = register A, 2 = register B, 3 = control. After reset all four read as zero, and the wave output and interrupt request are low. The control fields are: mode in bits 1:0 (0 pulse-width, 1 event, 2 capture, 3 difference), edge select in bit 2 (0 rising, 1 falling), interrupt enable in bit 3, run in bit 4, and pending flag in bit 5.
- R2: In pulse-width mode with run set, the counter steps down on every tick, and the wave output flips each time a tick finds the count at zero. A flip to high reloads from A and a flip to low reloads from B, so with a tick on every cycle the high level lasts A+1 cycles and the low level lasts B+1 cycles.
- R3: The pending flag is set by every underflow in pulse-width or event mode and by every captured edge in the two capture modes. Writing control with bit 5 set clears it, and a set in the same cycle wins over the clear.
- R4: The interrupt request is high exactly while the pending flag and the interrupt enable are both set.
- R5: In event mode the counter steps once per selected edge of the synchronized pin, and the tick input has no effect. On underflow it reloads from A. An edge of the other polarity changes nothing.
- R6: In capture mode the counter steps down on each tick and wraps from zero to 0xFFFF without setting the flag. A selected edge copies the counter into A and the old A into B.
- R7: In difference mode a selected edge writes into A the number of ticks since the previous selected edge, counting the tick of the current edge's cycle. The counter then restarts at 0xFFFF.
- R8: With run clear, neither the counter, the wave output nor the capture registers change, whatever the tick and pin inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Instruction-rate count enable |
| ext_pin | input | 1 | Asynchronous external timer input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is zero when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| pwm_out | output | 1 | Pulse-width wave output |
| irq | output | 1 | Interrupt request |

## Verification
The difference mode is driven from a table of pulse pairs. The gaps range from three cycles to a thousand, and both edge polarities appear. This separates an off-by-one in the elapsed-tick arithmetic from an edge-polarity mix-up. The pulse-width wave uses unequal A and B, so swapped reload registers show up as swapped level lengths. Event counting is driven with lone rising and lone falling transitions while ticks run, which shows whether the counter listens to the pin polarity or to the tick. Capture is tested with ticks stopped and then run for a known number of cycles, which pins down both the copied value and the A-to-B shift. A final count crossing zero confirms that the wrap does not raise the flag.

// File: rtl/mode_timer16_pkg.sv
package mode_timer16_pkg;

  typedef enum logic [1:0] {
    MODE_PWM   = 2'd0,
    MODE_EVENT = 2'd1,
    MODE_CAPT  = 2'd2,
    MODE_DIFF  = 2'd3
  } tmr_mode_e;

  // register addresses
  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_REGA  = 2'd1;
  localparam logic [ADDR_W-1:0] A_REGB  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd3;

  // control bit positions
  localparam int unsigned CB_FALL = 2;
  localparam int unsigned CB_IEN  = 3;
  localparam int unsigned CB_RUN  = 4;
  localparam int unsigned CB_PEND = 5;
  localparam int unsigned CTRL_W  = 6;

  typedef struct packed {
    logic      run;
    logic      irq_en;
    logic      fall;
    tmr_mode_e mode;
  } tmr_ctrl_t;

endpackage

// File: rtl/mode_timer16_edge.sv
module mode_timer16_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic sel_fall,
  output logic pin_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= cur;
  end

  assign pin_hit = sel_fall ? (last_q & ~cur) : (~last_q & cur);
endmodule

// File: rtl/mode_timer16_ctrl.sv
module mode_timer16_ctrl
  import mode_timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              set_pend,
  output tmr_ctrl_t         ctrl,
  output logic              pend,
  output logic              irq
);
  tmr_ctrl_t ctrl_q;
  logic      pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.mode   <= tmr_mode_e'(wdata[1:0]);
      ctrl_q.fall   <= wdata[CB_FALL];
      ctrl_q.irq_en <= wdata[CB_IEN];
      ctrl_q.run    <= wdata[CB_RUN];
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pend_q <= 1'b0;
    else if (set_pend)                  pend_q <= 1'b1;
    else if (wr_ctrl && wdata[CB_PEND]) pend_q <= 1'b0;
  end

  assign ctrl = ctrl_q;
  assign pend = pend_q;
  assign irq  = pend_q & ctrl_q.irq_en;
endmodule

// File: rtl/mode_timer16_core.sv
module mode_timer16_core
  import mode_timer16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         run,
  input  logic         tick,
  input  logic         hit,
  input  logic         wr_cnt,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rega,
  output logic [W-1:0] regb,
  output logic         pwm,
  output logic         ufl_evt,
  output logic         cap_evt
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic at_floor(input logic [W-1:0] v);
    return (v == '0);
  endfunction

  // ticks since restart at all-ones, plus the current cycle's tick
  function automatic logic [W-1:0] elapsed(input logic [W-1:0] v, input logic t);
    return (ALL_ONES - v) + (t ? ONE : '0);
  endfunction

  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] a_q, a_n;
  logic [W-1:0] b_q, b_n;
  logic         pwm_q, pwm_n;
  logic         ufl, cap;

  always_comb begin
    cnt_n = cnt_q;
    a_n   = a_q;
    b_n   = b_q;
    pwm_n = pwm_q;
    ufl   = 1'b0;
    cap   = 1'b0;
    unique case (mode)
      MODE_PWM: begin
        if (run && tick) begin
          if (at_floor(cnt_q)) begin
            ufl   = 1'b1;
            pwm_n = ~pwm_q;
            cnt_n = pwm_q ? b_q : a_q;
          end else begin
            cnt_n = step_down(cnt_q);
          end
        end
      end
      MODE_EVENT: begin
        if (run && hit) begin
          if (at_floor(cnt_q)) begin
            ufl   = 1'b1;
            cnt_n = a_q;
          end else begin
            cnt_n = step_down(cnt_q);
          end
        end
      end
      MODE_CAPT: begin
        if (run) begin
          if (tick) cnt_n = step_down(cnt_q);
          if (hit) begin
            cap = 1'b1;
            a_n = cnt_q;
            b_n = a_q;
          end
        end
      end
      MODE_DIFF: begin
        if (run) begin
          if (tick) cnt_n = step_down(cnt_q);
          if (hit) begin
            cap   = 1'b1;
            a_n   = elapsed(cnt_q, tick);
            cnt_n = ALL_ONES;
          end
        end
      end
      default: ;
    endcase
    if (wr_cnt)         cnt_n = wdata;
    if (wr_a && !cap)   a_n   = wdata;
    if (wr_b && !cap)   b_n   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      a_q   <= a_n;
      b_q   <= b_n;
      pwm_q <= pwm_n;
    end
  end

  assign cnt     = cnt_q;
  assign rega    = a_q;
  assign regb    = b_q;
  assign pwm     = pwm_q;
  assign ufl_evt = ufl;
  assign cap_evt = cap;
endmodule

// File: rtl/mode_timer16.sv
module mode_timer16
  import mode_timer16_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ext_pin,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              pwm_out,
  output logic              irq
);
  tmr_ctrl_t    ctrl;
  logic         pend;
  logic         pin_hit;
  logic         ufl_evt, cap_evt;
  logic [W-1:0] cnt, rega, regb;
  logic         wr_cnt, wr_a, wr_b, wr_ctrl;
  logic [W-1:0] rd_mux;

  assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
  assign wr_a    = bus_wr && (bus_addr == A_REGA);
  assign wr_b    = bus_wr && (bus_addr == A_REGB);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);

  mode_timer16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .sel_fall  (ctrl.fall),
    .pin_hit   (pin_hit)
  );

  mode_timer16_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wdata    (bus_wdata[CTRL_W-1:0]),
    .set_pend (ufl_evt | cap_evt),
    .ctrl     (ctrl),
    .pend     (pend),
    .irq      (irq)
  );

  mode_timer16_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (ctrl.mode),
    .run     (ctrl.run),
    .tick    (tick_en),
    .hit     (pin_hit),
    .wr_cnt  (wr_cnt),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .rega    (rega),
    .regb    (regb),
    .pwm     (pwm_out),
    .ufl_evt (ufl_evt),
    .cap_evt (cap_evt)
  );

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_COUNT: rd_mux = cnt;
      A_REGA:  rd_mux = rega;
      A_REGB:  rd_mux = regb;
      A_CTRL: begin
        rd_mux[1:0]     = ctrl.mode;
        rd_mux[CB_FALL] = ctrl.fall;
        rd_mux[CB_IEN]  = ctrl.irq_en;
        rd_mux[CB_RUN]  = ctrl.run;
        rd_mux[CB_PEND] = pend;
      end
      default: ;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/mode_timer16_chk.sv
module mode_timer16_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic         pwm_out,
  input logic         irq,
  input logic         ufl_evt,
  input logic         cap_evt,
  input logic         pin_hit,
  input logic         pend,
  input logic         irq_en,
  input logic         run,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt
);
  AST_PWM_FLIPS_ON_UFL: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out != $past(pwm_out)) |-> $past(ufl_evt)); // R2

  AST_PEND_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (ufl_evt || cap_evt) |=> pend); // R3

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && irq_en)); // R4

  AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !pin_hit && !bus_wr) |=> $stable(cnt)); // R5

  AST_DIFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && cap_evt && !bus_wr) |=> (cnt == {W{1'b1}})); // R7

  AST_RUN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> ($stable(cnt) && $stable(pwm_out))); // R8
endmodule

bind mode_timer16 mode_timer16_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .pwm_out (pwm_out),
  .irq     (irq),
  .ufl_evt (ufl_evt),
  .cap_evt (cap_evt),
  .pin_hit (pin_hit),
  .pend    (pend),
  .irq_en  (ctrl.irq_en),
  .run     (ctrl.run),
  .mode    (ctrl.mode),
  .cnt     (cnt)
);

// File: tb/mode_timer16_test.sv
`timescale 1ns/1ps
module mode_timer16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        ext_pin = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out, irq;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mode_timer16 uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_pin(ext_pin),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  // difference-mode vectors: {edge falling, gap cycles, expected A}
  localparam logic [32:0] DIFF_VEC [6] = '{
    {1'b0, 16'd3,    16'd3},
    {1'b0, 16'd8,    16'd8},
    {1'b1, 16'd5,    16'd5},
    {1'b1, 16'd37,   16'd37},
    {1'b0, 16'd250,  16'd250},
    {1'b1, 16'd1000, 16'd1000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pin_pulse(input logic idle);
    @(negedge clk); ext_pin = ~idle;
    repeat (2) @(negedge clk);
    ext_pin = idle;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int hi, lo, guard;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], v);
      check("R1 reset register", v, 16'h0000);
    end
    check("R1 reset pwm", {15'd0, pwm_out}, 16'd0);
    check("R1 reset irq", {15'd0, irq}, 16'd0);

    // R8 run clear: counter frozen
    bus_write(2'd0, 16'd7);
    tick_en = 1'b1;
    repeat (10) @(negedge clk);
    bus_read(2'd0, v);
    check("R8 frozen counter", v, 16'd7);
    check("R8 frozen pwm", {15'd0, pwm_out}, 16'd0);

    // R2 PWM phases, A=3 B=1
    bus_write(2'd1, 16'd3);
    bus_write(2'd2, 16'd1);
    bus_write(2'd0, 16'd0);
    bus_write(2'd3, 16'h0018);   // run, irq enable, pwm mode
    guard = 0;
    while (pwm_out !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    hi = 0;
    while (pwm_out === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (pwm_out === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    check("R2 high length A+1", 16'(hi), 16'd4);
    check("R2 low length B+1", 16'(lo), 16'd2);
    // R3/R4 pending and irq after underflow
    bus_read(2'd3, v);
    check("R3 pending after underflow", {15'd0, v[5]}, 16'd1);
    check("R4 irq with enable", {15'd0, irq}, 16'd1);
    bus_write(2'd3, 16'h0008);   // stop
    bus_write(2'd3, 16'h0028);   // clear pending
    bus_read(2'd3, v);
    check("R3 pending cleared", {15'd0, v[5]}, 16'd0);
    check("R4 irq low", {15'd0, irq}, 16'd0);

    // R5 event mode, rising select, ticks running
    tick_en = 1'b1;
    ext_pin = 1'b0;
    bus_write(2'd1, 16'd9);
    bus_write(2'd0, 16'd5);
    bus_write(2'd3, 16'h0011);   // run, event mode, rising
    repeat (4) @(negedge clk);
    bus_read(2'd0, v);
    check("R5 tick ignored", v, 16'd5);
    @(negedge clk); ext_pin = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(2'd0, v);
    check("R5 rising counted", v, 16'd4);
    @(negedge clk); ext_pin = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(2'd0, v);
    check("R5 falling ignored", v, 16'd4);
    for (int k = 0; k < 5; k++) pin_pulse(1'b0);
    repeat (3) @(negedge clk);
    bus_read(2'd0, v);
    check("R5 reload from A after underflow", v, 16'd9);
    bus_read(2'd3, v);
    check("R3 pending from event underflow", {15'd0, v[5]}, 16'd1);

    // R6 capture mode
    tick_en = 1'b0;
    bus_write(2'd3, 16'h0020);   // stop, clear
    bus_write(2'd1, 16'd0);
    bus_write(2'd0, 16'd1000);
    bus_write(2'd3, 16'h0012);   // run, capture, rising
    pin_pulse(1'b0);
    repeat (2) @(negedge clk);
    bus_read(2'd1, v);
    check("R6 first capture into A", v, 16'd1000);
    @(negedge clk); tick_en = 1'b1;
    repeat (50) @(negedge clk);
    tick_en = 1'b0;
    pin_pulse(1'b0);
    repeat (2) @(negedge clk);
    bus_read(2'd1, v);
    check("R6 second capture into A", v, 16'd950);
    bus_read(2'd2, v);
    check("R6 old A shifted to B", v, 16'd1000);
    bus_read(2'd3, v);
    check("R3 pending from capture", {15'd0, v[5]}, 16'd1);

    // R6 wrap without pending
    bus_write(2'd0, 16'd1);
    bus_write(2'd3, 16'h0032);   // clear pending, keep capture run
    @(negedge clk); tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    bus_read(2'd0, v);
    check("R6 wrap value", v, 16'hFFFE);
    bus_read(2'd3, v);
    check("R6 wrap leaves pending clear", {15'd0, v[5]}, 16'd0);

    // R7 difference-mode table
    tick_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic        fall;
      logic [15:0] gap, exp;
      fall = DIFF_VEC[i][32];
      gap  = DIFF_VEC[i][31:16];
      exp  = DIFF_VEC[i][15:0];
      @(negedge clk); ext_pin = fall;
      bus_write(2'd3, {10'd0, 6'h33} | {13'd0, fall, 2'b00});
      repeat (4) @(negedge clk);
      ext_pin = ~fall;
      @(negedge clk); ext_pin = fall;
      repeat (int'(gap) - 1) @(negedge clk);
      ext_pin = ~fall;
      @(negedge clk); ext_pin = fall;
      repeat (5) @(negedge clk);
      bus_read(2'd1, v);
      check("R7 elapsed ticks in A", v, exp);
      bus_read(2'd3, v);
      check("R7 pending after edge", {15'd0, v[5]}, 16'd1);
    end

    finish_run();
  end
endmodule